// File: doc/BRIEF.md
# Stopped-Clock Dual-Channel DAC Feeder

This block takes a two-channel I2S stream and re-times it for a pair of serial-input DACs that share one bit clock. The left word arrives first and is held in a buffer. When the right word arrives in the next slot, the right bits and the buffered left bits leave on two separate data lines, bit for bit, under one gated bit clock. That clock produces exactly one pulse per data bit and stays low for the rest of the frame. As a result, the unused trailing bits of each I2S slot never reach the DAC shift registers.

A latch output tells both DACs when to move their shifted word into the output register. The DACs act on the falling edge of this signal. In the default mode the block generates the latch itself, so that it is low across the first gated pulse and falls only after the last one. In the bypass mode the incoming word-select is passed straight through, so the latch edges keep the timing of the source.

All logic runs from the incoming I2S bit clock. The block captures on its rising edge and drives the outputs and the gate enable on its falling edge.

Top module: `sc_dac_feeder`

## Requirements
- R1: While reset is asserted, and after it until the first falling edge of `ws` has been sampled, `dac_gclk` makes no pulse and `dac_ldata`, `dac_rdata` and the generated latch stay low.
- R2: Each frame that follows a sampled falling edge of `ws` produces exactly one burst of WORD_BITS (default 20) pulses on `dac_gclk`, and every pulse falls inside the right slot (`ws` high).
- R3: The left word is the WORD_BITS bits that start one bit period after `ws` falls, MSB first. Any further bits in the left slot have no effect on what is sent.
- R4: On burst pulse k (k = 1..WORD_BITS), `dac_ldata` carries bit WORD_BITS-k of the left word and `dac_rdata` carries bit WORD_BITS-k of the right word (MSB on pulse 1). The right word is taken from the right slot in the same way as in R3.
- R5: Burst pulse k rises on the same `bclk` rising edge that samples bit index k of the right slot, where index 0 is the MSB. The burst therefore trails the right word's data by one bit period, and the data lines change only on falling `bclk` edges.
- R6: With `latch_bypass` = 0, `dac_latch` is low at burst pulse 1, high at pulses 2 to WORD_BITS, and falls once per burst, one `bclk` period after the last pulse has ended.
- R7: With `latch_bypass` = 1, `dac_latch` equals `ws` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | I2S bit clock; clocks all logic |
| rst_n | input | 1 | Active-low reset, synchronous to `bclk` |
| ws | input | 1 | I2S word select, low = left slot, high = right slot |
| sdata | input | 1 | I2S serial data, sampled on rising `bclk` |
| latch_bypass | input | 1 | 1 = pass `ws` to `dac_latch`, 0 = generated latch |
| dac_gclk | output | 1 | Gated bit clock shared by both DACs |
| dac_ldata | output | 1 | Serial left-channel word to the left DAC |
| dac_rdata | output | 1 | Serial right-channel word to the right DAC |
| dac_latch | output | 1 | Word/latch clock; DACs transfer on its falling edge |

## Verification
The hardest case to reach is a stream that starts in the middle of a right slot right after reset. In that case `ws` is already high and no left word has been captured, so the block must not open the gate even though it sees a right slot. The stimulus releases reset, then sends a complete right slot before any falling `ws` edge, and confirms that this slot produces no pulse before the first real frame follows. Random filler bits in every slot tail, together with a monitor that tracks each pulse against the slot bit index, expose any off-by-one in the burst placement.

// File: rtl/sc_feeder_pkg.sv
`timescale 1ns/1ps
// Package: shared types and defaults for the stopped-clock DAC feeder.
// Assumes: I2S convention, word select low marks the left slot.
package sc_feeder_pkg;

    // Default number of data bits delivered to each DAC per word.
    localparam int DEFAULT_WORD_BITS = 20;

    // Channel slot as indicated by the registered word select.
    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

endpackage

// File: rtl/sc_slot_capture.sv
`timescale 1ns/1ps
// Module: sc_slot_capture
// Tracks the bit position inside each I2S slot on rising bclk. Stores the
// left word and, during the right slot, presents one left bit and one right
// bit per cycle together with a run flag.
// Assumes: the MSB follows a word-select change by one bit period, and the
// slot is at least WORD_BITS long.
module sc_slot_capture
    import sc_feeder_pkg::*;
#(
    parameter int WORD_BITS = DEFAULT_WORD_BITS
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic ws,
    input  logic sdata,
    output logic run,
    output logic left_bit,
    output logic right_bit
);

    localparam int PW = $clog2(WORD_BITS + 1);
    localparam logic [PW-1:0] POS_END = PW'(WORD_BITS);

    logic                 ws_q;
    logic [PW-1:0]        pos;
    logic                 armed;
    logic [WORD_BITS-1:0] lreg;
    slot_e                slot_now;
    logic                 in_word;

    assign slot_now = slot_e'(ws_q);
    assign in_word  = (pos < POS_END);

    // Registered word select, bit position (saturating) and arming flag.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            ws_q  <= 1'b0;
            pos   <= POS_END;
            armed <= 1'b0;
        end else begin
            ws_q <= ws;
            if (ws != ws_q)
                pos <= '0;
            else if (in_word)
                pos <= pos + 1'b1;
            if (ws_q && !ws)
                armed <= 1'b1;
        end
    end

    // Left word capture in the left slot, left word release in the right slot.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            lreg      <= '0;
            run       <= 1'b0;
            left_bit  <= 1'b0;
            right_bit <= 1'b0;
        end else begin
            run <= 1'b0;
            if (slot_now == SLOT_LEFT && in_word) begin
                lreg <= {lreg[WORD_BITS-2:0], sdata};
            end else if (slot_now == SLOT_RIGHT && in_word && armed) begin
                run       <= 1'b1;
                left_bit  <= lreg[WORD_BITS-1];
                right_bit <= sdata;
                lreg      <= {lreg[WORD_BITS-2:0], 1'b0};
            end
        end
    end

    AST_POS_BOUNDED: assert property (@(posedge bclk) disable iff (!rst_n)
        pos <= POS_END); // R3
    AST_NO_RUN_UNARMED: assert property (@(posedge bclk) disable iff (!rst_n)
        !armed |=> !run); // R1

endmodule

// File: rtl/sc_clock_gate.sv
`timescale 1ns/1ps
// Module: sc_clock_gate
// Glitch-free gate for the DAC bit clock. The enable is registered on falling
// bclk, so it only changes while bclk is low and no runt pulse can appear.
// Assumes: run_req comes from rising-edge logic and is stable at falling bclk.
module sc_clock_gate
    import sc_feeder_pkg::*;
#(
    parameter int WORD_BITS = DEFAULT_WORD_BITS
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic run_req,
    output logic gate_en,
    output logic gclk
);

    localparam int BW = $clog2(WORD_BITS + 2);

    logic [BW-1:0] blen;

    // Enable register, updated while bclk is low.
    always_ff @(negedge bclk) begin
        if (!rst_n) gate_en <= 1'b0;
        else        gate_en <= run_req;
    end

    // Gated clock: high only during enabled bclk high phases.
    assign gclk = bclk & gate_en;

    // Burst length count that supports the assertions below.
    always_ff @(negedge bclk) begin
        if (!rst_n)       blen <= '0;
        else if (gate_en) blen <= blen + 1'b1;
        else              blen <= '0;
    end

    AST_BURST_LEN_MAX: assert property (@(negedge bclk) disable iff (!rst_n)
        blen <= BW'(WORD_BITS)); // R2
    AST_BURST_LEN_EXACT: assert property (@(negedge bclk) disable iff (!rst_n)
        $fell(gate_en) |-> blen == BW'(WORD_BITS)); // R2

endmodule

// File: rtl/sc_burst_driver.sv
`timescale 1ns/1ps
// Module: sc_burst_driver
// Drives both DAC data lines and the generated latch on falling bclk, so the
// data is stable at every rising gated-clock edge.
// Assumes: gate_en is the registered gate enable from sc_clock_gate.
module sc_burst_driver (
    input  logic bclk,
    input  logic rst_n,
    input  logic run,
    input  logic left_bit,
    input  logic right_bit,
    input  logic gate_en,
    output logic dac_l,
    output logic dac_r,
    output logic latch_gen
);

    // Data lines: current bit pair while running, low otherwise.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            dac_l <= 1'b0;
            dac_r <= 1'b0;
        end else begin
            dac_l <= run & left_bit;
            dac_r <= run & right_bit;
        end
    end

    // Generated latch: gate enable delayed by one bclk period.
    always_ff @(negedge bclk) begin
        if (!rst_n) latch_gen <= 1'b0;
        else        latch_gen <= gate_en;
    end

    AST_LATCH_LOW_AT_OPEN: assert property (@(negedge bclk) disable iff (!rst_n)
        $rose(gate_en) |-> !latch_gen); // R6
    AST_LATCH_FALL_CLOSED: assert property (@(negedge bclk) disable iff (!rst_n)
        $fell(latch_gen) |-> !gate_en); // R6
    AST_DATA_IDLE_LOW: assert property (@(negedge bclk) disable iff (!rst_n)
        !gate_en && !run |=> !dac_l && !dac_r); // R1

endmodule

// File: rtl/sc_dac_feeder.sv
`timescale 1ns/1ps
// Module: sc_dac_feeder (top)
// Turns an I2S stream into two time-aligned DAC data lines that share one
// stopped bit clock, plus a latch that is either generated or a copy of ws.
// Assumes: bclk is the only clock and rst_n is synchronous to it.
module sc_dac_feeder
    import sc_feeder_pkg::*;
#(
    parameter int WORD_BITS = DEFAULT_WORD_BITS
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic ws,
    input  logic sdata,
    input  logic latch_bypass,
    output logic dac_gclk,
    output logic dac_ldata,
    output logic dac_rdata,
    output logic dac_latch
);

    logic run;
    logic left_bit;
    logic right_bit;
    logic gate_en;
    logic latch_gen;

    sc_slot_capture #(.WORD_BITS(WORD_BITS)) u_capture (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .ws        (ws),
        .sdata     (sdata),
        .run       (run),
        .left_bit  (left_bit),
        .right_bit (right_bit)
    );

    sc_clock_gate #(.WORD_BITS(WORD_BITS)) u_gate (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .run_req (run),
        .gate_en (gate_en),
        .gclk    (dac_gclk)
    );

    sc_burst_driver u_driver (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .run       (run),
        .left_bit  (left_bit),
        .right_bit (right_bit),
        .gate_en   (gate_en),
        .dac_l     (dac_ldata),
        .dac_r     (dac_rdata),
        .latch_gen (latch_gen)
    );

    // Latch source: raw word select in bypass mode, generated latch otherwise.
    assign dac_latch = latch_bypass ? ws : latch_gen;

endmodule

// File: tb/sc_dac_feeder_bench.sv
`timescale 1ns/1ps
module sc_dac_feeder_bench;
    localparam int W    = 20;
    localparam int SLOT = 32;

    logic bclk  = 1'b0;
    logic rst_n = 1'b0;
    logic ws_i  = 1'b0;
    logic sd_i  = 1'b0;
    logic lsel  = 1'b0;
    wire  gclk, dl, dr, lat;

    always #2.5 bclk = ~bclk;

    sc_dac_feeder #(.WORD_BITS(W)) u_sc_dac_feeder (
        .bclk(bclk), .rst_n(rst_n), .ws(ws_i), .sdata(sd_i),
        .latch_bypass(lsel), .dac_gclk(gclk), .dac_ldata(dl),
        .dac_rdata(dr), .dac_latch(lat)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cur_idx = 0;
    logic [2*W-1:0] sbq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one slot, MSB first, random tail, ws switches on the last bit.
    task automatic send_slot(input logic [W-1:0] word, input logic wsv, input logic wsn);
        logic [SLOT-1:0] fill;
        fill = $urandom;
        for (int i = 0; i < SLOT; i++) begin
            @(negedge bclk); #1;
            cur_idx = i;
            ws_i = (i == SLOT-1) ? wsn : wsv;
            sd_i = (i < W) ? word[W-1-i] : fill[i];
        end
    endtask

    task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r);
        sbq.push_back({l, r});
        send_slot(l, 1'b0, 1'b1);
        send_slot(r, 1'b1, 1'b0);
    endtask

    // Monitor: collects burst bits and compares them with the scoreboard.
    int pn = 0;
    int last_burst = 0;
    int total = 0;
    logic [W-1:0] lw = '0;
    logic [W-1:0] rw = '0;
    always @(posedge bclk) begin
        logic [2*W-1:0] e;
        #1;
        if (rst_n && !done) begin
            if (gclk) begin
                pn++; total++;
                lw = {lw[W-2:0], dl};
                rw = {rw[W-2:0], dr};
                chk(ws_i == 1'b1, "R2", "pulse outside right slot", ws_i, 1);
                chk(cur_idx == pn, "R5", "pulse vs slot bit index", cur_idx, pn);
                if (!lsel) begin
                    if (pn == 1) chk(lat == 1'b0, "R6", "latch at first pulse", lat, 0);
                    else         chk(lat == 1'b1, "R6", "latch inside burst", lat, 1);
                end
                if (pn == W) begin
                    if (sbq.size() == 0) chk(1'b0, "R2", "unexpected burst", 1, 0);
                    else begin
                        e = sbq.pop_front();
                        chk(lw == e[2*W-1:W], "R3", "left word", lw, e[2*W-1:W]);
                        chk(rw == e[W-1:0], "R4", "right word", rw, e[W-1:0]);
                    end
                end
            end else if (pn != 0) begin
                chk(pn == W, "R2", "burst length", pn, W);
                last_burst = pn;
                pn = 0;
            end
            if (lsel) chk(lat == ws_i, "R7", "bypass latch follows ws", lat, ws_i);
        end
    end

    always @(negedge lat) begin
        if (rst_n && !lsel && !done)
            chk(last_burst == W && pn == 0, "R6", "latch fall after full burst", last_burst, W);
    end

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge bclk);
        #1;
        chk(gclk == 1'b0, "R1", "gclk in reset", gclk, 0);
        chk(dl == 1'b0, "R1", "left data in reset", dl, 0);
        chk(dr == 1'b0, "R1", "right data in reset", dr, 0);
        chk(lat == 1'b0, "R1", "latch in reset", lat, 0);
        @(negedge bclk); #1;
        rst_n = 1'b1;
        // Stream begins inside a right slot: no burst may be produced.
        send_slot(20'hABCDE, 1'b1, 1'b0);
        chk(total == 0, "R1", "pulses before first falling ws", total, 0);
        send_frame(20'hFFFFF, 20'h00000);
        send_frame(20'h00000, 20'hFFFFF);
        send_frame(20'hAAAAA, 20'h55555);
        send_frame(20'h80000, 20'h00001);
        send_frame(20'h12345, 20'hFEDCB);
        for (int k = 0; k < 3; k++) send_frame(W'($urandom), W'($urandom));
        lsel = 1'b1;
        send_frame(20'h0F0F0, 20'hC3C3C);
        send_frame(W'($urandom), W'($urandom));
        for (int k = 0; k < 40; k++) begin
            @(negedge bclk); #1;
            ws_i = 1'b0; sd_i = 1'b0;
        end
        chk(sbq.size() == 0, "R2", "every frame delivered", sbq.size(), 0);
        chk(gclk == 1'b0 && dl == 1'b0 && dr == 1'b0, "R1", "idle after stream", gclk, 0);
        finish_run();
    end
endmodule